// File: doc/BRIEF.md
# Motion-Vector Store Write Sequencer

This block works out where each macroblock of a picture's motion-vector record goes in memory. Software loads four registers: a picture-mode/width register, a remaining-count register, a position register and a byte base. After that, each macroblock write request is turned into one byte address and placed in a small queue. The queue drains towards memory through a valid/ready handshake. The packing of the macroblock data itself is done elsewhere.

The store groups macroblocks into vertical pairs. Each macroblock slot is 64 bytes, so a slot's address is the base plus 64 times its index. The block supports three picture modes:
- **Field pictures** step by two, so every other slot is used.
- **Paired-frame pictures** step by one.
- **Sequential-frame pictures** walk each pair row twice with a stride of two. The first pass covers the even slots. The second pass rewinds and covers the odd slots. For a row three pairs wide, the order is 0,2,4,1,3,5 and then 6,8,10,7,9,11.

Top module: `mvstore_wr_seq`

## Requirements
- R1: After reset the mode, remaining-count and position registers read zero, `q_full` is 0 and `mem_valid` is 0.
- R2: A host write with `cfg_we`=1 loads the register picked by `cfg_sel`. The `cfg_sel` encoding is:
  - 0: mode register from data bits 9:0, holding width in bits 7:0, paired-frame enable in bit 8 and field enable in bit 9.
  - 1: remaining-count register from data bits 15:0, holding X in bits 7:0 and Y in bits 15:8.
  - 2: position register from data bits 13:0, holding the index in bits 12:0 and the odd-pass flag in bit 13.
  - 3: base from data bits 31:6, with the low six bits taken as zero.
- R3: A request on `wr_req` is accepted only when X is nonzero, Y is nonzero and the queue is not full. A request that is not accepted changes no register and pushes no address.
- R4: An accepted request pushes the address base + index*64, using the index before the update.
- R5: After an accepted request, X drops by one. The index grows by 1 in paired-frame mode and by 2 otherwise. If both enables are set, paired-frame mode wins.
- R6: When X reaches zero, X reloads from the width, Y drops by one and the odd-pass flag toggles.
- R7: In sequential-frame mode, with both enables clear, entering an odd pass subtracts 2*width from the index and sets index bit 0. Entering an even pass clears index bit 0.
- R8: The queue holds 4 addresses. `q_full` is 1 exactly while 4 are held, and requests made then are ignored.
- R9: `mem_valid` is 1 while the queue is not empty. `mem_addr` is the oldest address, held steady until `mem_ready` completes the transfer. Addresses leave in the order they were pushed.
- R10: A host write to a register in the same cycle as an accepted request overrides the hardware update of that register only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 2 | Register select (0 mode, 1 remaining, 2 position, 3 base) |
| cfg_wdata | input | 32 | Host write data |
| wr_req | input | 1 | Macroblock write request |
| mode_o | output | 10 | Mode register contents |
| remain_o | output | 16 | Remaining-count register {Y, X} |
| posn_o | output | 14 | Position register {odd, index} |
| q_full | output | 1 | Queue full |
| mem_valid | output | 1 | Address available to memory |
| mem_addr | output | 32 | Byte address of oldest queued slot |
| mem_ready | input | 1 | Memory accepts the address |

## Verification
The bench builds the block with its default queue depth of 4 and the 13-bit index. With that depth, a handful of stalled-ready cycles is enough to reach the full flag. Small widths of 1 to 5 make pass ends, Y running out and the sequential-frame rewind happen every few requests. Random bases, positions and concurrent host writes take the index arithmetic through wrap-around and the same-cycle priority case.

// File: rtl/mvs_seq_pkg.sv
package mvs_seq_pkg;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = 13;
  localparam int ADDR_W = 32;
  localparam int SLOT_SHIFT = 6;

  typedef enum logic [1:0] {
    MODE_SEQ_FRAME  = 2'd0,
    MODE_PAIR_FRAME = 2'd1,
    MODE_FIELD      = 2'd2
  } pic_mode_e;

  typedef struct packed {
    logic             odd;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] y;
    logic [CNT_W-1:0] x;
  } seq_state_t;

  function automatic pic_mode_e decode_mode(input logic pair_en, input logic field_en);
    if (pair_en)       return MODE_PAIR_FRAME;
    else if (field_en) return MODE_FIELD;
    else               return MODE_SEQ_FRAME;
  endfunction

  function automatic seq_state_t advance(input seq_state_t s, input logic [CNT_W-1:0] width,
                                         input pic_mode_e m);
    seq_state_t n;
    logic [IDX_W-1:0] span;
    n     = s;
    span  = IDX_W'({width, 1'b0});
    n.x   = s.x - 1'b1;
    n.idx = s.idx + ((m == MODE_PAIR_FRAME) ? IDX_W'(1) : IDX_W'(2));
    if (n.x == '0) begin
      n.x   = width;
      n.y   = s.y - 1'b1;
      n.odd = ~s.odd;
      if (m == MODE_SEQ_FRAME) begin
        if (n.odd) begin
          n.idx    = n.idx - span;
          n.idx[0] = 1'b1;
        end else begin
          n.idx[0] = 1'b0;
        end
      end
    end
    return n;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + (ADDR_W'(idx) << SLOT_SHIFT);
  endfunction
endpackage

// File: rtl/mvs_pass_ctrl.sv
module mvs_pass_ctrl
  import mvs_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [31:0]       host_data,
  input  logic              step,
  output logic [9:0]        mode_reg,
  output logic [15:0]       remain_reg,
  output logic [13:0]       posn_reg,
  output logic              can_write,
  output logic [ADDR_W-1:0] cur_addr
);
  seq_state_t        st_q, st_step;
  logic [9:0]        mode_q;
  logic [ADDR_W-1:0] base_q;
  pic_mode_e         mode;
  logic [CNT_W-1:0]  width;

  assign width     = mode_q[CNT_W-1:0];
  assign mode      = decode_mode(mode_q[8], mode_q[9]);
  assign st_step   = step ? advance(st_q, width, mode) : st_q;
  assign can_write = (st_q.x != '0) && (st_q.y != '0);
  assign cur_addr  = slot_addr(base_q, st_q.idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      mode_q <= '0;
      base_q <= '0;
    end else begin
      st_q <= st_step;
      if (host_we) begin
        case (host_sel)
          2'd0: mode_q <= host_data[9:0];
          2'd1: {st_q.y, st_q.x} <= host_data[15:0];
          2'd2: {st_q.odd, st_q.idx} <= host_data[13:0];
          default: base_q <= {host_data[ADDR_W-1:SLOT_SHIFT], {SLOT_SHIFT{1'b0}}};
        endcase
      end
    end
  end

  assign mode_reg   = mode_q;
  assign remain_reg = {st_q.y, st_q.x};
  assign posn_reg   = {st_q.odd, st_q.idx};

  logic hw_only;
  assign hw_only = step && !host_we;

  assert_pass_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_only && st_q.x == 8'd1) |=> (st_q.x == $past(width) && st_q.odd != $past(st_q.odd)
                                     && st_q.y == $past(st_q.y) - 8'd1));
  assert_pair_stride_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_only && mode == MODE_PAIR_FRAME && st_q.x != 8'd1) |=> st_q.idx == $past(st_q.idx) + 13'd1);
  assert_odd_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_only && mode == MODE_SEQ_FRAME && st_q.x == 8'd1 && !st_q.odd) |=> st_q.idx[0]);
  assert_even_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_only && mode == MODE_SEQ_FRAME && st_q.x == 8'd1 && st_q.odd) |=> !st_q.idx[0]);
endmodule

// File: rtl/mvs_wr_queue.sv
module mvs_wr_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          not_empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout      = mem[rp];
  assign not_empty = (cnt != '0);
  assign full      = (cnt == CW'(DEPTH));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/mvstore_wr_seq.sv
module mvstore_wr_seq
  import mvs_seq_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        wr_req,
  output logic [9:0]  mode_o,
  output logic [15:0] remain_o,
  output logic [13:0] posn_o,
  output logic        q_full,
  output logic        mem_valid,
  output logic [31:0] mem_addr,
  input  logic        mem_ready
);
  logic              can_write, accept, pop;
  logic [ADDR_W-1:0] cur_addr;

  assign accept = wr_req && can_write && !q_full;
  assign pop    = mem_valid && mem_ready;

  mvs_pass_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_we(cfg_we), .host_sel(cfg_sel), .host_data(cfg_wdata),
    .step(accept),
    .mode_reg(mode_o), .remain_reg(remain_o), .posn_reg(posn_o),
    .can_write(can_write), .cur_addr(cur_addr)
  );

  mvs_wr_queue #(.DEPTH(QDEPTH), .DW(ADDR_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(accept), .din(cur_addr),
    .pop(pop), .dout(mem_addr),
    .not_empty(mem_valid), .full(q_full)
  );

  assert_drop_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !accept && !cfg_we) |=> ($stable(remain_o) && $stable(posn_o)));
  assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
endmodule

// File: tb/test_mvstore_wr_seq.sv
module test_mvstore_wr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        wr_req = 1'b0;
  logic        mem_ready = 1'b0;
  logic [9:0]  mode_o;
  logic [15:0] remain_o;
  logic [13:0] posn_o;
  logic        q_full, mem_valid;
  logic [31:0] mem_addr;

  always #2 clk = ~clk;

  mvstore_wr_seq i_mvstore_wr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wr_req(wr_req), .mode_o(mode_o), .remain_o(remain_o), .posn_o(posn_o),
    .q_full(q_full), .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic [9:0]  m_mode = '0;
  int          m_x = 0, m_y = 0, m_idx = 0, m_odd = 0;
  logic [31:0] m_base = '0;
  logic [31:0] mq [8];
  int          mcnt = 0;
  logic [31:0] taken [32];
  int          ntaken = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_index(input int idx, input int width, input logic pair,
                                    input logic seq, input int enter_odd, input int pass_end);
    int r;
    r = idx + (pair ? 1 : 2);
    if (pass_end && seq) begin
      if (enter_odd) r = (r - width * 2) | 1;
      else           r = r & ~1;
    end
    return r & 8191;
  endfunction

  task automatic model_edge(input logic req, input logic rdy, input logic we,
                            input logic [1:0] sel, input logic [31:0] d);
    logic acc, pop, pair, seq;
    int   w, pe;
    logic [31:0] a;
    pop  = (mcnt != 0) && rdy;
    acc  = req && m_x != 0 && m_y != 0 && mcnt < 4;
    a    = m_base + 32'(m_idx) * 32'd64;
    if (pop) begin
      for (int k = 0; k < 7; k++) mq[k] = mq[k+1];
      mcnt--;
    end
    if (acc) begin
      mq[mcnt] = a;
      mcnt++;
      w    = int'(m_mode[7:0]);
      pair = m_mode[8];
      seq  = !m_mode[8] && !m_mode[9];
      m_x  = m_x - 1;
      pe   = (m_x == 0);
      if (pe) begin
        m_x = w; m_y = m_y - 1; m_odd = 1 - m_odd;
      end
      m_idx = next_index(m_idx, w, pair, seq, m_odd, pe);
    end
    if (we) begin
      case (sel)
        2'd0: m_mode = d[9:0];
        2'd1: begin m_x = int'(d[7:0]); m_y = int'(d[15:8]); end
        2'd2: begin m_idx = int'(d[12:0]); m_odd = int'(d[13]); end
        default: m_base = d & 32'hFFFF_FFC0;
      endcase
    end
  endtask

  task automatic compare_all();
    check("R9 mem_valid", 32'(mem_valid), 32'(mcnt != 0));
    if (mcnt != 0) check("R4 mem_addr", mem_addr, mq[0]);
    check("R8 q_full", 32'(q_full), 32'(mcnt == 4));
    check("R6 remain", 32'(remain_o), 32'({m_y[7:0], m_x[7:0]}));
    check("R7 position", 32'(posn_o), 32'({m_odd[0], m_idx[12:0]}));
    check("R2 mode", 32'(mode_o), 32'(m_mode));
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input logic req, input logic rdy, input logic we,
                     input logic [1:0] sel, input logic [31:0] d);
    wr_req = req; mem_ready = rdy; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    if (mem_valid && rdy && ntaken < 32) begin
      taken[ntaken] = mem_addr;
      ntaken++;
    end
    @(posedge clk);
    model_edge(req, rdy, we, sel, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic host(input logic [1:0] sel, input logic [31:0] d);
    cyc(1'b0, 1'b0, 1'b1, sel, d);
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) cyc(1'b0, 1'b1, 1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] pos0, rem0;
    int exp_order [12];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(mem_valid), 0);
    check("R1 full", 32'(q_full), 0);
    check("R1 remain", 32'(remain_o), 0);
    check("R1 position", 32'(posn_o), 0);
    check("R1 mode", 32'(mode_o), 0);

    // R2 register loads, base low bits dropped
    host(2'd0, 32'hFFFF_F3FF);
    check("R2 mode mask", 32'(mode_o), 32'h3FF);
    host(2'd3, 32'h0001_007F);
    host(2'd0, 32'h0000_0003);
    host(2'd2, 32'h0000_0000);

    // R3 X zero: request dropped
    host(2'd1, 32'h0000_0400);
    pos0 = 16'(posn_o);
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 0);
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 0);
    check("R3 no push", 32'(mem_valid), 0);
    check("R3 position kept", 32'(posn_o), 32'(pos0));

    // R7 sequential-frame order over two pair rows, width 3
    host(2'd1, 32'h0000_0403);
    ntaken = 0;
    for (int k = 0; k < 14; k++) cyc(1'b1, 1'b1, 1'b0, 2'd0, 0);
    drain();
    exp_order = '{0, 2, 4, 1, 3, 5, 6, 8, 10, 7, 9, 11};
    check("R7 count", 32'(ntaken), 12);
    for (int k = 0; k < 12; k++)
      check("R7 order", taken[k], 32'h0001_0040 + 32'(exp_order[k]) * 64);
    // R3 Y exhausted: further requests dropped
    rem0 = remain_o;
    cyc(1'b1, 1'b1, 1'b0, 2'd0, 0);
    check("R3 Y zero kept", 32'(remain_o), 32'(rem0));
    check("R3 Y zero no push", 32'(mem_valid), 0);

    // R8 queue fills at 4 with ready low
    host(2'd0, 32'h0000_0114);
    host(2'd1, 32'h0000_0214);
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 1'b0, 2'd0, 0);
    check("R8 full flag", 32'(q_full), 1);
    check("R8 only four taken", 32'(remain_o[7:0]), 32'd16);
    // R9 address stable while not ready
    cyc(1'b0, 1'b0, 1'b0, 2'd0, 0);
    drain();

    // R10 host write to position during an accepted request
    host(2'd2, 32'h0000_0010);
    cyc(1'b1, 1'b1, 1'b1, 2'd2, 32'h0000_2100);
    check("R10 host wins", 32'(posn_o), 32'h2100);
    check("R10 X still stepped", 32'(remain_o[7:0]), 32'd15);
    drain();

    // R5 field and both-enable cases, then randomized runs per mode
    for (int md = 0; md < 4; md++) begin
      logic [31:0] w;
      w = 32'($urandom_range(1, 5));
      host(2'd0, (32'(md) << 8) | w);
      host(2'd1, ((32'($urandom_range(2, 6))) << 8) | w);
      host(2'd2, 32'($urandom) & 32'h3FFF);
      host(2'd3, $urandom);
      for (int k = 0; k < 300; k++) begin
        logic we;
        logic [1:0] sel;
        logic [31:0] d;
        we  = ($urandom_range(0, 99) < 3);
        sel = 2'($urandom_range(1, 3));
        d   = (sel == 2'd1) ? ((32'($urandom_range(0, 4)) << 8) | 32'($urandom_range(0, 5))) : $urandom;
        cyc(($urandom_range(0, 99) < 70), ($urandom_range(0, 99) < 50), we, sel, d);
      end
      drain();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule